// File: doc/BRIEF.md
# Dead-Band Heater Controller with Thermal Plant Model

This block closes a small temperature loop on chip. A clocked on/off controller compares a signed set-point with a signed measured temperature and drives one heater-enable bit. The controller has a symmetric hold band around the set-point, so the heater does not chatter when the temperature is near the target. A synthesizable plant model sits in the same loop. It keeps a temperature register that climbs while the heater is on and sinks back toward an ambient floor while it is off. The climb rate and the sink rate are set by two independent clock prescalers. The integer temperature is fed straight back to the controller as its measurement.

The set-point is an input port, so the loop can be retargeted at run time. The ambient floor, the band half-width, the prescaler ratios and the data width are parameters. The defaults are 7-bit two's-complement temperatures (-64 to 63), an ambient of 10, a band of 2, a rise of one unit per 4 heated clocks and a fall of one unit per 10 unheated clocks. A set-point of 22 is the usual operating point.

Top module: `thermo_loop`

## Requirements
- R1: A synchronous active-high `rst` forces `heaterOn` to 0, loads the plant temperature with the ambient value (10 by default) and clears both prescalers.
- R2: At a rising clock edge the heater is switched on when the measured temperature is at or below the set-point minus 2.
- R3: At a rising clock edge the heater is switched off when the measured temperature is at or above the set-point plus 2.
- R4: When the measured temperature lies strictly between set-point minus 2 and set-point plus 2, `heaterOn` keeps its previous value.
- R5: While `heaterOn` is 1, the plant temperature rises by one unit on every fourth clock. The prescaler starts from zero each time the heater turns on.
- R6: While `heaterOn` is 0, the plant temperature falls by one unit on every tenth clock. The prescaler starts from zero each time the heater turns off.
- R7: The plant never cools below the ambient value.
- R8: The plant temperature saturates at +63 and never wraps.
- R9: The set-point plus or minus 2 is formed one bit wider than the data, so set-point 63 never turns the heater off and set-point -64 never turns it on.
- R10: In closed loop with a fixed set-point, once settled, the measured temperature stays within the set-point ±3.
- R11: In settled closed loop, each heater-on run lasts at least 16 clocks and each heater-off run lasts at least 40 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| setPoint | input | 7 | Target temperature, two's complement |
| heaterOn | output | 1 | Registered heater enable |
| measTemp | output | 7 | Plant temperature, two's complement, fed back to the controller |

## Verification
The assertions assume that `setPoint` changes only between clock edges. They also assume that reset is held for at least two clocks, so that the step-size property has a defined previous temperature. The bench drives every input on the falling edge and holds reset for several cycles. It only uses set-points inside the 7-bit range. This includes both extreme values, which the widened threshold arithmetic has to handle without overflow.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  // Strobes from the control to the datapath: one plant step each.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } plantStep_t;

  // Threshold results reported by the datapath to the control.
  typedef struct packed {
    logic coldHit;
    logic hotHit;
  } cmpFlags_t;

endpackage

// File: rtl/thermo_prescale.sv
// Modulo-DIV counter that runs only while enabled. It emits one tick on
// the DIV-th enabled clock, and restarts from zero whenever it is disabled.
module thermo_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/thermo_control.sv
// Control side of the loop: the heater register and the two rate prescalers.
module thermo_control
  import thermo_pkg::*;
#(
  parameter int RISE_DIV = 4,
  parameter int FALL_DIV = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  cmpFlags_t  flags,
  output logic       heaterOn,
  output plantStep_t step
);
  logic heatReg;
  logic riseTick;
  logic fallTick;

  // Dead-band decision: cold wins when both hit (not reachable with BAND>0).
  always_ff @(posedge clk) begin
    if (rst)               heatReg <= 1'b0;
    else if (flags.coldHit) heatReg <= 1'b1;
    else if (flags.hotHit)  heatReg <= 1'b0;
  end

  thermo_prescale #(.DIV(RISE_DIV)) risePre_i (
    .clk (clk),
    .rst (rst),
    .en  (heatReg),
    .tick(riseTick)
  );

  thermo_prescale #(.DIV(FALL_DIV)) fallPre_i (
    .clk (clk),
    .rst (rst),
    .en  (!heatReg),
    .tick(fallTick)
  );

  assign heaterOn      = heatReg;
  assign step.stepUp   = riseTick;
  assign step.stepDown = fallTick;
endmodule

// File: rtl/thermo_datapath.sv
// Datapath side: plant temperature register and widened threshold compares.
module thermo_datapath
  import thermo_pkg::*;
#(
  parameter int TEMP_W  = 7,
  parameter int BAND    = 2,
  parameter int AMBIENT = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [TEMP_W-1:0] setPoint,
  input  plantStep_t               step,
  output logic signed [TEMP_W-1:0] measTemp,
  output cmpFlags_t                flags
);
  localparam int WIDE_W = TEMP_W + 1;
  localparam logic signed [TEMP_W-1:0] T_MAX  = TEMP_W'((1 << (TEMP_W - 1)) - 1);
  localparam logic signed [TEMP_W-1:0] AMB_V  = TEMP_W'(AMBIENT);
  localparam logic signed [WIDE_W-1:0] BAND_W = WIDE_W'(BAND);

  logic signed [TEMP_W-1:0] tempReg;
  logic signed [WIDE_W-1:0] spWide;
  logic signed [WIDE_W-1:0] tempWide;
  logic signed [WIDE_W-1:0] lowThr;
  logic signed [WIDE_W-1:0] highThr;

  always_ff @(posedge clk) begin
    if (rst)
      tempReg <= AMB_V;
    else if (step.stepUp && (tempReg != T_MAX))
      tempReg <= tempReg + 1'b1;
    else if (step.stepDown && (tempReg > AMB_V))
      tempReg <= tempReg - 1'b1;
  end

  always_comb begin
    spWide   = {setPoint[TEMP_W-1], setPoint};
    tempWide = {tempReg[TEMP_W-1], tempReg};
    lowThr   = spWide - BAND_W;
    highThr  = spWide + BAND_W;
    flags.coldHit = (tempWide <= lowThr);
    flags.hotHit  = (tempWide >= highThr);
  end

  assign measTemp = tempReg;
endmodule

// File: rtl/thermo_loop.sv
// Thin top: joins the control and the datapath into a closed loop.
module thermo_loop
  import thermo_pkg::*;
#(
  parameter int TEMP_W   = 7,
  parameter int BAND     = 2,
  parameter int AMBIENT  = 10,
  parameter int RISE_DIV = 4,
  parameter int FALL_DIV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] setPoint,
  output logic              heaterOn,
  output logic [TEMP_W-1:0] measTemp
);
  plantStep_t stepBus;
  cmpFlags_t  flagBus;
  logic signed [TEMP_W-1:0] tempSig;

  thermo_control #(
    .RISE_DIV(RISE_DIV),
    .FALL_DIV(FALL_DIV)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .flags   (flagBus),
    .heaterOn(heaterOn),
    .step    (stepBus)
  );

  thermo_datapath #(
    .TEMP_W (TEMP_W),
    .BAND   (BAND),
    .AMBIENT(AMBIENT)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .setPoint($signed(setPoint)),
    .step    (stepBus),
    .measTemp(tempSig),
    .flags   (flagBus)
  );

  assign measTemp = tempSig;
endmodule

// File: rtl/thermo_loop_chk.sv
module thermo_loop_chk #(
  parameter int TEMP_W  = 7,
  parameter int BAND    = 2,
  parameter int AMBIENT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [TEMP_W-1:0] setPoint,
  input logic              heaterOn,
  input logic [TEMP_W-1:0] measTemp
);
  localparam int WIDE_W = TEMP_W + 1;
  localparam logic signed [WIDE_W-1:0] BAND_W = WIDE_W'(BAND);
  localparam logic signed [TEMP_W-1:0] AMB_V  = TEMP_W'(AMBIENT);
  localparam logic signed [TEMP_W-1:0] T_MAX  = TEMP_W'((1 << (TEMP_W - 1)) - 1);

  logic signed [WIDE_W-1:0] spW;
  logic signed [WIDE_W-1:0] tW;
  logic signed [TEMP_W-1:0] tS;
  assign spW = {setPoint[TEMP_W-1], setPoint};
  assign tW  = {measTemp[TEMP_W-1], measTemp};
  assign tS  = $signed(measTemp);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!heaterOn && (tS == AMB_V)));

  p_cold_on_r2: assert property (@(posedge clk) disable iff (rst)
    (tW <= spW - BAND_W) |=> heaterOn);

  p_hot_off_r3: assert property (@(posedge clk) disable iff (rst)
    (tW >= spW + BAND_W) |=> !heaterOn);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((tW > spW - BAND_W) && (tW < spW + BAND_W)) |=> $stable(heaterOn));

  p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(measTemp) |-> ((tS == $past(tS) + 1'sb1) || (tS == $past(tS) - 1'sb1)));

  p_no_rise_off_r6: assert property (@(posedge clk) disable iff (rst)
    !heaterOn |=> (tS <= $past(tS)));

  p_floor_r7: assert property (@(posedge clk) disable iff (rst)
    tS >= AMB_V);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (heaterOn && (tS == T_MAX)) |=> (tS == T_MAX));
endmodule

bind thermo_loop thermo_loop_chk #(
  .TEMP_W (TEMP_W),
  .BAND   (BAND),
  .AMBIENT(AMBIENT)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .setPoint(setPoint),
  .heaterOn(heaterOn),
  .measTemp(measTemp)
);

// File: tb/thermo_loop_tb_top.sv
module thermo_loop_tb_top;
  localparam int AMB = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] setPoint = 7'd0;
  logic       heaterOn;
  logic [6:0] measTemp;

  int errors = 0;
  int checks = 0;
  int sp = 0;
  bit modelOn = 1'b0;

  // Reference state built from the requirements.
  int mTemp = AMB;
  int mRise = 0;
  int mFall = 0;
  bit mHeat = 1'b0;

  // Segment table: set-point, length, expected heater and temperature at end.
  localparam int VEC_N = 5;
  localparam int SP_TAB  [VEC_N] = '{12, 11,  9, 12, 14};
  localparam int LEN_TAB [VEC_N] = '{ 3,  6,  2,  5,  2};
  localparam int EH_TAB  [VEC_N] = '{ 1,  1,  0,  0,  1};
  localparam int ET_TAB  [VEC_N] = '{10, 12, 12, 12, 12};

  always #5 clk = ~clk;

  thermo_loop dut_i (
    .clk     (clk),
    .rst     (rst),
    .setPoint(setPoint),
    .heaterOn(heaterOn),
    .measTemp(measTemp)
  );

  function automatic int tempNow();
    return int'($signed(measTemp));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model update.
  always @(posedge clk) begin
    bit nh;
    if (rst) begin
      mHeat = 1'b0; mTemp = AMB; mRise = 0; mFall = 0;
    end else begin
      nh = mHeat;
      if (mTemp <= sp - 2)      nh = 1'b1;
      else if (mTemp >= sp + 2) nh = 1'b0;
      if (mHeat) begin
        mFall = 0;
        if (mRise == 3) begin
          mRise = 0;
          if (mTemp < 63) mTemp = mTemp + 1;
        end else mRise = mRise + 1;
      end else begin
        mRise = 0;
        if (mFall == 9) begin
          mFall = 0;
          if (mTemp > AMB) mTemp = mTemp - 1;
        end else mFall = mFall + 1;
      end
      mHeat = nh;
    end
  end

  // Per-cycle comparison against the model (R2 R3 R4 R5 R6 R7 R8).
  always @(negedge clk) begin
    if (modelOn && !rst) begin
      chk("R2/R3/R4 heater vs model", int'(heaterOn), int'(mHeat));
      chk("R5/R6/R7/R8 temp vs model", tempNow(), mTemp);
    end
  end

  task automatic setSp(input int v);
    sp = v;
    setPoint = 7'(v);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 heater after reset", int'(heaterOn), 0);
    chk("R1 temp after reset", tempNow(), AMB);
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int runStart;
    bit prevH;
    @(negedge clk);
    setSp(0);
    doReset();
    modelOn = 1'b1;

    // Table walk: hold band behaviour at ambient (R2 R3 R4).
    for (int v = 0; v < VEC_N; v++) begin
      setSp(SP_TAB[v]);
      repeat (LEN_TAB[v]) @(negedge clk);
      chk("R4 table heater", int'(heaterOn), EH_TAB[v]);
      chk("R5 table temp", tempNow(), ET_TAB[v]);
    end

    // R5: exact rise timing from reset.
    setSp(0);
    doReset();
    setSp(30);
    repeat (4) @(negedge clk);
    chk("R2 heater on at 10 for sp 30", int'(heaterOn), 1);
    chk("R5 temp before 4th heated clock", tempNow(), 10);
    @(negedge clk);
    chk("R5 temp after 4th heated clock", tempNow(), 11);
    repeat (4) @(negedge clk);
    chk("R5 temp after next 4 clocks", tempNow(), 12);

    // R8 and R9: set-point 63 drives to saturation, heater stays on.
    setSp(63);
    repeat (260) @(negedge clk);
    chk("R8 saturated temp", tempNow(), 63);
    chk("R9 heater stays on at sp 63", int'(heaterOn), 1);

    // R6: exact fall timing.
    setSp(-64);
    @(negedge clk);
    chk("R3 heater off at sp -64", int'(heaterOn), 0);
    repeat (9) @(negedge clk);
    chk("R6 temp before 10th unheated clock", tempNow(), 63);
    @(negedge clk);
    chk("R6 temp after 10th unheated clock", tempNow(), 62);

    // R7 and R9: cool to the floor and stay there.
    repeat (600) @(negedge clk);
    chk("R7 temp at ambient floor", tempNow(), AMB);
    chk("R9 heater stays off at sp -64", int'(heaterOn), 0);
    repeat (50) @(negedge clk);
    chk("R7 temp still at floor", tempNow(), AMB);

    // R10 R11: settled closed loop at 22.
    setSp(22);
    runStart = 0;
    prevH = heaterOn;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i >= 1500) begin
        chk("R10 temp not below sp-3", int'(tempNow() >= 19), 1);
        chk("R10 temp not above sp+3", int'(tempNow() <= 25), 1);
      end
      if (heaterOn != prevH) begin
        if (runStart >= 1500) begin
          if (prevH) chk("R11 on run at least 16", int'(i - runStart >= 16), 1);
          else       chk("R11 off run at least 40", int'(i - runStart >= 40), 1);
        end
        runStart = i;
        prevH = heaterOn;
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule